// File: doc/BRIEF.md
# Video thumbnail capture buffer

This block sits on the final pixel stream of a video generator, after palette lookup, sprite overlay and raster effects have been applied. It keeps a reduced 80x50 copy of the picture in a 4096-byte buffer. Because it taps the composited output, the thumbnail shows what the screen shows, and no frame buffer is needed. The block takes one source pixel at a fixed horizontal and vertical stride and stores its colour, reduced to one byte. It does not average neighbouring pixels.

Two parameters set the strides: the active width divided by 80 and the active height divided by 50. Samples are written into one port of a dual-port memory. A supervisor reads the buffer out through the other port, using a one-byte data register whose address moves on by one after each read. The address wraps at the buffer size. A write to a second register puts the address back to zero. Supervisor reads therefore never hold up capture.

Top module: `thumb_capture`

## Requirements
- R1: Each stored byte is packed as red in bits 7:5 (pix_rgb[23:21]), green in bits 4:2 (pix_rgb[15:13]) and blue in bits 1:0 (pix_rgb[7:6]). It is the packed value of one source pixel, not an average.
- R2: Within a line, x counts the valid pixels from 0. Lines count from 0, starting at the frame-start line. A pixel is stored when x is a multiple of HSTRIDE and y is a multiple of VSTRIDE. It goes to address (y/VSTRIDE)*80 + x/HSTRIDE.
- R3: A cycle with pix_valid low neither stores a sample nor advances the horizontal position.
- R4: frame_start marks line 0 of a new frame. Any line_start pulses seen before it have no effect on which source lines are sampled.
- R5: Each thumbnail row holds exactly 80 samples. Pixels past the 80th sampled column of a line are not stored, so they never spill into the next row.
- R6: Source lines past the 50th sampled row of a frame are not stored.
- R7: A cycle with reg_rd high and reg_sel low (the data register) loads reg_rdata with the byte at the read address from the next cycle on. The address then increments.
- R8: The read address wraps from 4095 to 0.
- R9: A cycle with reg_wr high and reg_sel high (the pointer-reset register) sets the read address to 0.
- R10: After reset, reg_rdata is 0 and the read address is 0.
- R11: reg_rdata holds its value in cycles with no data-register read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; also clocks the register port |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | pix_rgb carries an active pixel this cycle |
| pix_rgb | input | 24 | Composited pixel: red 23:16, green 15:8, blue 7:0 |
| line_start | input | 1 | One-cycle pulse before the pixels of each later line |
| frame_start | input | 1 | One-cycle pulse before the pixels of the first line of a frame |
| reg_sel | input | 1 | Register select: 0 data, 1 pointer reset |
| reg_rd | input | 1 | Read strobe for the data register |
| reg_wr | input | 1 | Write strobe for the pointer-reset register |
| reg_rdata | output | 8 | Byte returned by the last data read |

## Verification
The assertions assume that line_start and frame_start arrive only in cycles where pix_valid is low. They also assume that a data read never targets the address being written in the same cycle. The bench holds the strobes in their own idle cycles and reads the buffer back only after each frame has ended. The stimulus includes frames with idle pixel gaps, extra pixels on each line, extra lines and stray line strobes before frame_start. The expected image is computed separately, so any sample that lands in the wrong place shows up in the full readback.

// File: rtl/thumb_pkg.sv
package thumb_pkg;

  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_PTR  = 1'b1
  } reg_sel_e;

  // Reduce a 24-bit colour to 3:3:2 by keeping the top bits of each channel
  function automatic logic [7:0] rgb_to_332(input logic [23:0] rgb);
    return {rgb[23:21], rgb[15:13], rgb[7:6]};
  endfunction

  // Linear buffer address of a thumbnail cell
  function automatic int unsigned cell_addr(input int unsigned row,
                                            input int unsigned col,
                                            input int unsigned width);
    return row * width + col;
  endfunction

endpackage

// File: rtl/thumb_sampler.sv
module thumb_sampler
  import thumb_pkg::*;
#(
  parameter int HSTRIDE = 8,
  parameter int VSTRIDE = 8,
  parameter int THUMB_W = 80,
  parameter int THUMB_H = 50,
  parameter int AW      = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic [23:0]   pix_rgb,
  input  logic          line_start,
  input  logic          frame_start,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);

  localparam int HPW = (HSTRIDE > 1) ? $clog2(HSTRIDE) : 1;
  localparam int VPW = (VSTRIDE > 1) ? $clog2(VSTRIDE) : 1;
  localparam int CW  = $clog2(THUMB_W + 1);
  localparam int RW  = $clog2(THUMB_H + 1);

  logic [HPW-1:0] hph;
  logic [VPW-1:0] vph;
  logic [CW-1:0]  hcol;
  logic [RW-1:0]  vrow;
  logic           new_line;
  logic           sample_hit;
  logic           hph_wrap;
  logic           vph_wrap;

  assign new_line   = line_start | frame_start;
  assign hph_wrap   = (hph == HPW'(HSTRIDE - 1));
  assign vph_wrap   = (vph == VPW'(VSTRIDE - 1));
  assign sample_hit = pix_valid && !new_line && (hph == '0) && (vph == '0)
                      && (hcol < CW'(THUMB_W)) && (vrow < RW'(THUMB_H));

  // horizontal position within a line; saturates past the last column
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hph  <= '0;
      hcol <= CW'(THUMB_W);
    end else if (new_line) begin
      hph  <= '0;
      hcol <= '0;
    end else if (pix_valid) begin
      if (hph_wrap) begin
        hph <= '0;
        if (hcol < CW'(THUMB_W)) hcol <= hcol + CW'(1);
      end else begin
        hph <= hph + HPW'(1);
      end
    end
  end

  // vertical position; idle (saturated) until the first frame_start
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vph  <= '0;
      vrow <= RW'(THUMB_H);
    end else if (frame_start) begin
      vph  <= '0;
      vrow <= '0;
    end else if (line_start) begin
      if (vph_wrap) begin
        vph <= '0;
        if (vrow < RW'(THUMB_H)) vrow <= vrow + RW'(1);
      end else begin
        vph <= vph + VPW'(1);
      end
    end
  end

  assign wr_en   = sample_hit;
  assign wr_addr = AW'(cell_addr(int'(vrow), int'(hcol), THUMB_W));
  assign wr_data = rgb_to_332(pix_rgb);

  // independent tally of samples taken in the current line
  logic [CW:0] line_hits;
  always_ff @(posedge clk) begin
    if (!rst_n)          line_hits <= '0;
    else if (new_line)   line_hits <= '0;
    else if (sample_hit) line_hits <= line_hits + 1'b1;
  end

  // R5
  row_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_hit |-> (line_hits < (CW+1)'(THUMB_W)));

  // R6
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < THUMB_W * THUMB_H));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid && !new_line) |=> ($stable(hph) && $stable(hcol)));

  // R4
  frame_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (vrow == '0 && vph == '0));

endmodule

// File: rtl/thumb_ram.sv
module thumb_ram #(
  parameter int DEPTH = 4096,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata));

endmodule

// File: rtl/thumb_readport.sv
module thumb_readport
  import thumb_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          reg_rd,
  input  logic          reg_wr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr
);

  logic ptr_clr;

  assign rd_en   = reg_rd && (reg_sel == SEL_DATA);
  assign ptr_clr = reg_wr && (reg_sel == SEL_PTR);

  // address wraps naturally at 2**AW
  always_ff @(posedge clk) begin
    if (!rst_n)       rd_addr <= '0;
    else if (ptr_clr) rd_addr <= '0;
    else if (rd_en)   rd_addr <= rd_addr + AW'(1);
  end

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !ptr_clr) |=> (rd_addr == $past(rd_addr) + AW'(1)));

  // R9
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> (rd_addr == '0));

endmodule

// File: rtl/thumb_capture.sv
module thumb_capture #(
  parameter int ACTIVE_W  = 640,
  parameter int ACTIVE_H  = 400,
  parameter int THUMB_W   = 80,
  parameter int THUMB_H   = 50,
  parameter int BUF_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pix_valid,
  input  logic [23:0] pix_rgb,
  input  logic        line_start,
  input  logic        frame_start,
  input  logic        reg_sel,
  input  logic        reg_rd,
  input  logic        reg_wr,
  output logic [7:0]  reg_rdata
);

  localparam int HSTRIDE = ACTIVE_W / THUMB_W;
  localparam int VSTRIDE = ACTIVE_H / THUMB_H;
  localparam int AW      = $clog2(BUF_BYTES);

  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          rd_en;
  logic [AW-1:0] rd_addr;

  thumb_sampler #(
    .HSTRIDE(HSTRIDE), .VSTRIDE(VSTRIDE),
    .THUMB_W(THUMB_W), .THUMB_H(THUMB_H), .AW(AW)
  ) u_sampler (
    .clk(clk), .rst_n(rst_n),
    .pix_valid(pix_valid), .pix_rgb(pix_rgb),
    .line_start(line_start), .frame_start(frame_start),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  thumb_ram #(.DEPTH(BUF_BYTES), .AW(AW)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .re(rd_en), .raddr(rd_addr), .rdata(reg_rdata)
  );

  thumb_readport #(.AW(AW)) u_port (
    .clk(clk), .rst_n(rst_n),
    .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .rd_en(rd_en), .rd_addr(rd_addr)
  );

  // R10
  reset_out_chk: assert property (@(posedge clk)
    !rst_n |=> (reg_rdata == 8'h00));

endmodule

// File: tb/sim_thumb_capture.sv
module sim_thumb_capture;

  localparam int AW_PIX = 160;
  localparam int AH_PIX = 100;
  localparam int TW     = 80;
  localparam int TH     = 50;
  localparam int HS     = AW_PIX / TW;
  localparam int VS     = AH_PIX / TH;
  localparam int NCELL  = TW * TH;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0;
  logic [23:0] pix_rgb = '0;
  logic        line_start = 1'b0;
  logic        frame_start = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_rdata;

  int checks = 0;
  int failures = 0;

  logic [7:0] exp_img [NCELL];
  logic [7:0] q_val [$];
  bit         q_chk [$];
  string      q_tag [$];

  always #4 clk = ~clk;

  thumb_capture #(
    .ACTIVE_W(AW_PIX), .ACTIVE_H(AH_PIX),
    .THUMB_W(TW), .THUMB_H(TH), .BUF_BYTES(4096)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .pix_valid(pix_valid), .pix_rgb(pix_rgb),
    .line_start(line_start), .frame_start(frame_start),
    .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_rdata(reg_rdata)
  );

  function automatic logic [23:0] pattern(int f, int x, int y);
    logic [7:0] r, g, b;
    r = 8'(x * 7 + f * 31 + y);
    g = 8'(y * 13 + x * 3 + f);
    b = 8'(x ^ (y * 5) ^ (f * 77));
    return {r, g, b};
  endfunction

  // bench restatement of the 3:3:2 packing (R1)
  function automatic logic [7:0] pack(logic [23:0] c);
    logic [7:0] o;
    o[7] = c[23]; o[6] = c[22]; o[5] = c[21];
    o[4] = c[15]; o[3] = c[14]; o[2] = c[13];
    o[1] = c[7];  o[0] = c[6];
    return o;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic strobe_line(input bit first);
    @(negedge clk);
    pix_valid = 1'b0;
    if (first) frame_start = 1'b1; else line_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    line_start = 1'b0;
  endtask

  // driver: sends one frame and records the expected thumbnail
  task automatic drive_frame(int f, int extra_px, int extra_ln, bit gaps);
    for (int y = 0; y < AH_PIX + extra_ln; y++) begin
      strobe_line(y == 0);
      for (int x = 0; x < AW_PIX + extra_px; x++) begin
        if (gaps && (x % 7 == 3)) begin
          pix_valid = 1'b0;
          pix_rgb = 24'hFFFFFF;
          @(negedge clk);
        end
        pix_valid = 1'b1;
        pix_rgb = pattern(f, x, y);
        if ((x % HS == 0) && (y % VS == 0) && (x / HS < TW) && (y / VS < TH))
          exp_img[(y / VS) * TW + x / HS] = pack(pattern(f, x, y));
        @(negedge clk);
      end
      pix_valid = 1'b0;
    end
  endtask

  task automatic ptr_reset();
    @(negedge clk);
    reg_sel = 1'b1;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    reg_sel = 1'b0;
  endtask

  task automatic rd_byte(input logic [7:0] exp, input bit chk, input string tag);
    @(negedge clk);
    reg_sel = 1'b0;
    reg_rd = 1'b1;
    q_val.push_back(exp);
    q_chk.push_back(chk);
    q_tag.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // monitor: pops one expected item per data read
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && reg_rd && !reg_sel) begin
        logic [7:0] e;
        bit c;
        string t;
        @(negedge clk);
        e = q_val.pop_front();
        c = q_chk.pop_front();
        t = q_tag.pop_front();
        if (c) check(t, reg_rdata, e);
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] last;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: output after reset
    check("R10 reset rdata", reg_rdata, 8'h00);

    // plain frame, then full readback (R1, R2, R7)
    drive_frame(0, 0, 0, 1'b0);
    ptr_reset();
    for (int i = 0; i < NCELL; i++) rd_byte(exp_img[i], 1'b1, "R1/R2/R7 readback");
    last = exp_img[NCELL-1];
    repeat (6) @(negedge clk);
    // R11: no read, no change
    check("R11 rdata held", reg_rdata, last);

    // R8: finish the 4096-byte sweep, then the address is back at 0
    for (int i = NCELL; i < 4096; i++) rd_byte(8'h00, 1'b0, "");
    rd_byte(exp_img[0], 1'b1, "R8 wrap to 0");

    // R9: pointer reset in mid-stream
    for (int i = 1; i < 4; i++) rd_byte(exp_img[i], 1'b1, "R9 pre-reset step");
    ptr_reset();
    rd_byte(exp_img[0], 1'b1, "R9 pointer cleared");

    // R4: stray line strobes before the frame; R3 gaps, R5 long lines, R6 extra lines
    for (int k = 0; k < 3; k++) strobe_line(1'b0);
    drive_frame(1, 6, 12, 1'b1);
    ptr_reset();
    for (int i = 0; i < NCELL; i++) rd_byte(exp_img[i], 1'b1, "R3/R4/R5/R6 readback");

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule